// File: doc/BRIEF.md
# Serial Clock and Frame-Sync Generator

This block produces the bit clock and a periodic frame-sync pulse for a synchronous serial port. It runs entirely on the peripheral clock. It divides that clock by a programmable amount, and the ratio depends on whether the port moves data out or in. A divisor value N gives a serial clock of one 4(N+1)-th of the peripheral clock when transmitting and one 8(N+1)-th when receiving. The output has a 50% duty cycle.

A second counter counts rising edges of the serial clock and raises the frame-sync output for one full serial-clock period once every F+1 serial clocks. When the block is the clock master, the edges counted are those of its own divider. When it is not, they come from an external serial clock that is first passed through a two-flop synchronizer. The frame-sync output carries a direction tag that marks it as a transmit or receive frame sync. Any change to the divisor, the frame-sync period, the direction or the master control restarts both counters from a clean state. If only a general clock output is wanted, it is enough to set the master control and the divisor.

Top module: `sclk_fs_gen`

## Requirements
- R1: While `rst_n` is low, `sclk_o` and `fs_o` are 0.
- R2: With `ctl_master`=1 and `dir_tx`=1, `sclk_o` toggles every 2(N+1) peripheral clocks, where N = `div_reg[15:1]`. Its first rise comes 2(N+1) clocks after the restart edge, and each high phase lasts at least 2 clocks.
- R3: With `ctl_master`=1 and `dir_tx`=0, `sclk_o` toggles every 4(N+1) peripheral clocks, and its first rise comes 4(N+1) clocks after the restart edge.
- R4: `div_reg[0]` is ignored: flipping it neither restarts the counters nor shifts any `sclk_o` or `fs_o` edge.
- R5: With N=0 in transmit mode, `sclk_o` runs at a quarter of the peripheral clock (2 high, 2 low), and no low phase is shorter than 2 clocks.
- R6: Counting rising serial-clock edges from 1 after a restart, `fs_o` is set at rise number F+1 and then at every further F+1 rises, where F = `fsdiv`. With F=0 it stays high from the first rise onward.
- R7: `fs_o` changes only on a rising serial-clock edge or a restart. Each pulse therefore lasts exactly one serial-clock period.
- R8: With `ctl_master`=0, `sclk_o` is held at 0, and `fs_o` follows R6 counting rising edges of `ext_sclk`. Each such edge takes effect within 4 peripheral clocks.
- R9: `fs_dir` equals the value of `dir_tx` one peripheral clock earlier (1 = transmit frame sync, 0 = receive frame sync).
- R10: A change of `div_reg[15:1]`, `fsdiv`, `dir_tx` or `ctl_master`, sampled at a clock edge, drives `sclk_o` and `fs_o` to 0 at that edge and restarts both counters from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_reg | input | 16 | Clock divisor N in bits 15:1; bit 0 is reserved |
| fsdiv | input | 16 | Frame-sync period F, in serial clocks minus one |
| ctl_master | input | 1 | 1: internal divider drives the serial clock; 0: external clock is used |
| dir_tx | input | 1 | 1: data lines transmit; 0: data lines receive |
| ext_sclk | input | 1 | External serial clock, asynchronous to `clk` |
| sclk_o | output | 1 | Generated serial clock |
| fs_o | output | 1 | Frame-sync pulse |
| fs_dir | output | 1 | Direction tag of the frame sync: 1 transmit, 0 receive |

## Verification
The divider is driven in transmit mode at N=0, N=2 and N=3 and in receive mode at N=1 and N=100. These runs separate the 2(N+1) ratio from the 4(N+1) ratio, and they expose any off-by-one error in the terminal count, both at the fastest rate and at a long period. Frame-sync periods of 0, 1, 2 and 3 are combined with these settings, so the bench can tell a pulse on the correct rise from one a rise early or late and can catch a pulse that is too short or too long. A run that flips the reserved divisor bit partway through shows whether that bit wrongly restarts the counters. An external-clock run with the master control off checks that edges from the synchronizer, not from the idle divider, advance the frame counter.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  // Source of the edges that advance the frame counter
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_INT = 1'b1
  } sclk_src_e;

  // Data direction that the frame sync belongs to
  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } port_dir_e;
endpackage

// File: rtl/sfg_clk_div.sv
module sfg_clk_div #(
  parameter int NW = 15,
  localparam int HW = NW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          restart,
  input  logic          rx_mode,
  input  logic [NW-1:0] div_n,
  output logic          sclk,
  output logic          rise_stb
);
  logic [HW-1:0] half_len;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          at_end;

  always_comb begin
    if (rx_mode) half_len = ({{3{1'b0}}, div_n} + HW'(1)) << 2;
    else         half_len = ({{3{1'b0}}, div_n} + HW'(1)) << 1;
  end

  assign at_end = (cnt_q == half_len - HW'(1));

  always_comb begin
    cnt_d    = cnt_q;
    sclk_d   = sclk_q;
    rise_stb = 1'b0;
    if (restart || !en) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (at_end) begin
      cnt_d    = '0;
      sclk_d   = ~sclk_q;
      rise_stb = ~sclk_q;
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/sfg_ext_sync.sv
module sfg_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_stb
);
  logic [STAGES:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], async_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise_stb = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/sfg_fs_cnt.sv
module sfg_fs_cnt #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [FW-1:0] limit,
  output logic          fs
);
  logic [FW-1:0] fcnt_q, fcnt_d;
  logic          fs_q, fs_d;

  always_comb begin
    fcnt_d = fcnt_q;
    fs_d   = fs_q;
    if (restart) begin
      fcnt_d = '0;
      fs_d   = 1'b0;
    end else if (tick) begin
      if (fcnt_q == limit) begin
        fcnt_d = '0;
        fs_d   = 1'b1;
      end else begin
        fcnt_d = fcnt_q + FW'(1);
        fs_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      fs_q   <= 1'b0;
    end else begin
      fcnt_q <= fcnt_d;
      fs_q   <= fs_d;
    end
  end

  assign fs = fs_q;
endmodule

// File: rtl/sclk_fs_gen.sv
module sclk_fs_gen #(
  parameter int DIVREG_W = 16,
  parameter int FS_W     = 16,
  parameter int SYNC_STG = 2,
  localparam int NW      = DIVREG_W - 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIVREG_W-1:0] div_reg,
  input  logic [FS_W-1:0]     fsdiv,
  input  logic                ctl_master,
  input  logic                dir_tx,
  input  logic                ext_sclk,
  output logic                sclk_o,
  output logic                fs_o,
  output logic                fs_dir
);
  import sfg_pkg::*;

  logic [NW-1:0]   div_q;
  logic [FS_W-1:0] fsdiv_q;
  logic            dir_q, mst_q;
  logic            restart;
  logic            int_rise, ext_rise, tick;
  sclk_src_e       src;
  port_dir_e       pdir;
  logic            div_lsb_unused;

  assign div_lsb_unused = div_reg[0];
  assign src  = ctl_master ? SRC_INT : SRC_EXT;
  assign pdir = dir_tx ? DIR_TX : DIR_RX;

  assign restart = (div_reg[DIVREG_W-1:1] != div_q) || (fsdiv != fsdiv_q) ||
                   (dir_tx != dir_q) || (ctl_master != mst_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      fsdiv_q <= '0;
      dir_q   <= 1'b0;
      mst_q   <= 1'b0;
    end else begin
      div_q   <= div_reg[DIVREG_W-1:1];
      fsdiv_q <= fsdiv;
      dir_q   <= dir_tx;
      mst_q   <= ctl_master;
    end
  end

  sfg_clk_div #(.NW(NW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (src == SRC_INT),
    .restart  (restart),
    .rx_mode  (pdir == DIR_RX),
    .div_n    (div_reg[DIVREG_W-1:1]),
    .sclk     (sclk_o),
    .rise_stb (int_rise)
  );

  sfg_ext_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_sclk),
    .rise_stb (ext_rise)
  );

  assign tick = (src == SRC_INT) ? int_rise : ext_rise;

  sfg_fs_cnt #(.FW(FS_W)) u_fs (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (tick),
    .limit   (fsdiv),
    .fs      (fs_o)
  );

  assign fs_dir = dir_q;
endmodule

// File: rtl/sclk_fs_gen_chk.sv
module sclk_fs_gen_chk #(
  parameter int DIVREG_W = 16,
  parameter int FS_W     = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DIVREG_W-1:0] div_reg,
  input logic [FS_W-1:0]     fsdiv,
  input logic                ctl_master,
  input logic                dir_tx,
  input logic                ext_sclk,
  input logic                sclk_o,
  input logic                fs_o,
  input logic                fs_dir
);
  logic ext_seen;
  assign ext_seen = ext_sclk;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_rst_quiet_r1: assert (!sclk_o && !fs_o)
        else $error("R1: outputs active during reset");
    end
  end

  // R7: no frame-sync change away from a serial rise unless config changed
  p_fs_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(div_reg[DIVREG_W-1:1]) && $stable(fsdiv) && $stable(dir_tx) &&
     $stable(ctl_master) && ctl_master && !$rose(sclk_o)) |-> $stable(fs_o));

  // R8: serial clock output quiet when not master
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_master |=> !sclk_o);

  // R5: low phase of at least two peripheral clocks
  p_low_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !$past(sclk_o, 2));

  // R2: high phase of at least two peripheral clocks when config is steady
  p_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(div_reg[DIVREG_W-1:1]) && $stable(fsdiv) && $stable(dir_tx) &&
     $stable(ctl_master) && $fell(sclk_o)) |-> $past(sclk_o, 2));

  // R9: direction tag follows the direction input one clock later
  p_dir_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(dir_tx) |=> (fs_dir == $past(dir_tx)));
endmodule

bind sclk_fs_gen sclk_fs_gen_chk #(.DIVREG_W(DIVREG_W), .FS_W(FS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_reg    (div_reg),
  .fsdiv      (fsdiv),
  .ctl_master (ctl_master),
  .dir_tx     (dir_tx),
  .ext_sclk   (ext_sclk),
  .sclk_o     (sclk_o),
  .fs_o       (fs_o),
  .fs_dir     (fs_dir)
);

// File: tb/sclk_fs_gen_tb_top.sv
module sclk_fs_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] div_reg;
  logic [15:0] fsdiv;
  logic        ctl_master;
  logic        dir_tx;
  logic        ext_sclk;
  logic        sclk_o;
  logic        fs_o;
  logic        fs_dir;

  int n_vec;
  int n_bad;

  sclk_fs_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_reg    (div_reg),
    .fsdiv      (fsdiv),
    .ctl_master (ctl_master),
    .dir_tx     (dir_tx),
    .ext_sclk   (ext_sclk),
    .sclk_o     (sclk_o),
    .fs_o       (fs_o),
    .fs_dir     (fs_dir)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input int cyc);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // Set a configuration; the following posedge is the restart edge (c=1)
  task automatic apply_cfg(input int n, input int f, input logic dir, input logic m);
    @(negedge clk);
    ctl_master = ~m;
    div_reg    = {n[14:0], 1'b0};
    fsdiv      = f[15:0];
    dir_tx     = dir;
    @(negedge clk);
    ctl_master = m;
  endtask

  // Master-mode run: check serial clock, frame sync and tag against the model
  task automatic run_master(input int n, input int f, input logic dir, input int ncyc,
                            input int flip_at, input string req);
    int h;
    h = dir ? 2 * (n + 1) : 4 * (n + 1);
    apply_cfg(n, f, dir, 1'b1);
    for (int c = 1; c <= ncyc; c++) begin
      int rises;
      int exp_fs;
      if (c == flip_at) begin
        @(negedge clk);
        div_reg[0] = ~div_reg[0];   // R4: reserved bit must have no effect
      end
      @(posedge clk);
      #1;
      rises  = (c - 1 + h) / (2 * h);
      exp_fs = (rises > 0 && ((rises - 1) % (f + 1)) == f) ? 1 : 0;
      if (c == 1) begin
        check("R10", int'(sclk_o), 0, c);
        check("R9", int'(fs_dir), int'(dir), c);
      end
      check(flip_at > 0 && c >= flip_at ? "R4" : req, int'(sclk_o), ((c - 1) / h) % 2, c);
      check(f == 0 ? "R6" : "R7", int'(fs_o), exp_fs, c);
    end
  endtask

  task automatic t_reset();
    rst_n      = 1'b0;
    div_reg    = '0;
    fsdiv      = '0;
    ctl_master = 1'b0;
    dir_tx     = 1'b0;
    ext_sclk   = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(sclk_o), 0, 0);
    check("R1", int'(fs_o), 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_ext();
    int f;
    f = 2;
    apply_cfg(5, f, 1'b0, 1'b0);
    ext_sclk = 1'b0;
    for (int r = 1; r <= 8; r++) begin
      @(negedge clk);
      ext_sclk = 1'b1;
      repeat (6) @(posedge clk);
      #1;
      check("R8", int'(fs_o), (((r - 1) % (f + 1)) == f) ? 1 : 0, r);
      check("R8", int'(sclk_o), 0, r);
      @(negedge clk);
      ext_sclk = 1'b0;
      repeat (6) @(posedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    t_reset();
    run_master(0, 0, 1'b1, 40, 0, "R5");
    run_master(2, 3, 1'b1, 120, 0, "R2");
    run_master(1, 1, 1'b0, 130, 0, "R3");
    run_master(3, 2, 1'b1, 160, 21, "R2");
    run_master(100, 0, 1'b0, 2000, 0, "R3");
    t_ext();
    run_master(0, 1, 1'b0, 64, 0, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule